// File: doc/BRIEF.md
# Master and Processor Clock Enable Generator

This block derives two clock-enable pulse trains, one for the processor and one for the master (bus) clock, from one of four source clocks. Each source reaches the block as a one-cycle tick in a fast reference clock domain: slow clock, main oscillator, first PLL and second PLL. The selected tick stream is first divided by a power-of-two prescaler. The prescaled stream becomes the processor-clock enable. A master divider then passes one of every 1, 2, 3 or 4 processor enables as the master-clock enable.

Software writes a configuration word that is held as pending. The pending word becomes active only in the cycle that closes a master-clock period. As a result, a change of source, prescale or ratio never cuts a period short. Both pulse outputs and the active configuration are registered.

Top module: `mck_clock_gen`

## Requirements
- R1: While reset is high, and after it is released until the first write takes effect, `act_cfg` reads 0 (slow clock, prescale 1, ratio 1), and `pck_en` and `mck_en` are low during reset.
- R2: The source field is `cfg_wdata[1:0]`. The codes are 0 = slow (`src_tick[0]`), 1 = main (`src_tick[1]`), 2 = first PLL (`src_tick[2]`) and 3 = second PLL (`src_tick[3]`). Only ticks of the selected source advance the outputs.
- R3: The prescale field is `cfg_wdata[4:2]`. For codes 0 to 6, `pck_en` fires once every 2^code ticks of the selected source.
- R4: Prescale code 7 is reserved and divides by 1, so `pck_en` fires once per source tick.
- R5: The ratio field is `cfg_wdata[6:5]`. Codes 0, 1, 2 and 3 give exactly 1, 2, 3 and 4 `pck_en` pulses per master period. The interval between `mck_en` pulses is that many `pck_en` intervals, with no drift.
- R6: Every `mck_en` pulse falls in the same cycle as a `pck_en` pulse. With ratio code 0 the two outputs are identical.
- R7: `act_cfg` changes only in a cycle in which `mck_en` is high, which is the end of a master period.
- R8: A write (`cfg_we` high) is stored as pending. If several writes land inside one master period, the last one is applied. A write that lands in the same cycle as a period boundary is applied at the following boundary, not at that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One-cycle ticks from the four sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word {ratio, prescale, source} |
| pck_en | output | 1 | Processor-clock enable pulse |
| mck_en | output | 1 | Master-clock enable pulse |
| act_cfg | output | 7 | Configuration currently in force |

## Verification
A configuration write and the end of a master period can fall in the same cycle. The bench provokes this by first choosing the first PLL with prescale 1 and ratio 1, so that every cycle is a boundary. It then writes a new word and samples `act_cfg` one and two cycles later. The word must still be the old one after the first edge and the new one after the second. A slow configuration then shows that a mid-period write waits for `mck_en`, and that back-to-back writes leave only the last one applied.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int SRC_N  = 4;
  localparam int CSS_W  = $clog2(SRC_N);
  localparam int PRES_W = 3;
  localparam int MDIV_W = 2;
  localparam int CFG_W  = CSS_W + PRES_W + MDIV_W;

  typedef enum logic [CSS_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL0 = 2'd2,
    SRC_PLL1 = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic [MDIV_W-1:0] ratio;
    logic [PRES_W-1:0] pres;
    src_sel_e          src;
  } mck_cfg_t;

  localparam mck_cfg_t CFG_RESET = '{ratio: '0, pres: '0, src: SRC_SLOW};
endpackage

// File: rtl/mck_src_mux.sv
module mck_src_mux #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  tick_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SW'(i)) tick_o = tick_i[i];
    end
  end
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
  parameter int PRES_W = 3,
  localparam int CNT_W = (1 << PRES_W) - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [PRES_W-1:0] pres_i,
  output logic              hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   pow;
  logic [CNT_W:0]   pow_m1;
  logic [CNT_W-1:0] lim;

  always_comb begin
    pow    = {{CNT_W{1'b0}}, 1'b1} << pres_i;
    pow_m1 = pow - 1'b1;
    lim    = (pres_i == '1) ? '0 : pow_m1[CNT_W-1:0];
  end

  assign hit_o = tick_i && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mck_master_div.sv
module mck_master_div #(
  parameter int MDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [MDIV_W-1:0] ratio_i,
  output logic              hit_o
);
  logic [MDIV_W-1:0] cnt_q;

  assign hit_o = step_i && (cnt_q == ratio_i);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mck_clock_gen.sv
module mck_clock_gen
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             pck_en,
  output logic             mck_en,
  output logic [CFG_W-1:0] act_cfg
);
  mck_cfg_t pend_q, act_q;
  logic     sel_tick, pre_hit, mck_hit;

  mck_src_mux #(.N(SRC_N)) u_mux (
    .tick_i (src_tick),
    .sel_i  (act_q.src),
    .tick_o (sel_tick)
  );

  mck_prescaler #(.PRES_W(PRES_W)) u_pres (
    .clk    (clk),
    .rst    (rst),
    .tick_i (sel_tick),
    .pres_i (act_q.pres),
    .hit_o  (pre_hit)
  );

  mck_master_div #(.MDIV_W(MDIV_W)) u_mdiv (
    .clk     (clk),
    .rst     (rst),
    .step_i  (pre_hit),
    .ratio_i (act_q.ratio),
    .hit_o   (mck_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= CFG_RESET;
      act_q  <= CFG_RESET;
      pck_en <= 1'b0;
      mck_en <= 1'b0;
    end else begin
      if (cfg_we)  pend_q <= mck_cfg_t'(cfg_wdata);
      if (mck_hit) act_q  <= pend_q;
      pck_en <= pre_hit;
      mck_en <= mck_hit;
    end
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/mck_clock_gen_chk.sv
module mck_clock_gen_chk
  import mck_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pck_en,
  input logic             mck_en,
  input logic [CFG_W-1:0] act_cfg
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (act_cfg == '0 && !pck_en && !mck_en));

  p_mck_on_pck_r6: assert property (@(posedge clk) disable iff (rst)
    mck_en |-> pck_en);

  p_ratio1_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (pck_en && $past(act_cfg[CFG_W-1 -: MDIV_W]) == '0) |-> mck_en);

  p_cfg_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_cfg) |-> mck_en);
endmodule

bind mck_clock_gen mck_clock_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pck_en  (pck_en),
  .mck_en  (mck_en),
  .act_cfg (act_cfg)
);

// File: tb/tb_mck_clock_gen.sv
module tb_mck_clock_gen;
  import mck_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SRC_N-1:0] src_tick = '0;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             pck_en, mck_en;
  logic [CFG_W-1:0] act_cfg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int per [SRC_N] = '{5, 3, 1, 2};
  int tcnt[SRC_N] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  mck_clock_gen dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pck_en(pck_en), .mck_en(mck_en), .act_cfg(act_cfg)
  );

  always @(negedge clk) begin
    for (int i = 0; i < SRC_N; i++) begin
      src_tick[i] <= (tcnt[i] == 0);
      tcnt[i]     <= (tcnt[i] + 1 == per[i]) ? 0 : tcnt[i] + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk(input int src, input int pres, input int ratio);
    return {2'(ratio), 3'(pres), 2'(src)};
  endfunction

  task automatic wr(input logic [CFG_W-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_applied(input logic [CFG_W-1:0] w, input string tag);
    int n = 0;
    while (!(act_cfg == w && mck_en) && n < 4000) begin
      @(negedge clk); n++;
    end
    chk(n < 4000, tag, int'(act_cfg), int'(w));
  endtask

  task automatic wait_mck();
    int n = 0;
    do begin @(negedge clk); n++; end while (!mck_en && n < 4000);
  endtask

  task automatic measure(input int exp_gap, input int ratio);
    int c = 0, npck = 0, gap = -1;
    bit coinc = 1'b1;
    wait_mck();
    do begin
      @(negedge clk); c++;
      if (pck_en) begin
        npck++;
        if (npck == 1) gap = c;
      end
      if (mck_en && !pck_en) coinc = 1'b0;
    end while (!mck_en && c < 4000);
    chk(gap == exp_gap, "R2/R3/R4 pck interval", gap, exp_gap);
    chk(npck == ratio, "R5 pck per mck", npck, ratio);
    chk(c == exp_gap * ratio, "R5 mck interval", c, exp_gap * ratio);
    chk(coinc, "R6 mck with pck", int'(coinc), 1);
  endtask

  initial begin
    logic [CFG_W-1:0] w, a, b;
    repeat (3) @(negedge clk);
    chk(act_cfg == '0, "R1 act_cfg in reset", int'(act_cfg), 0);
    chk(!pck_en && !mck_en, "R1 pulses low in reset", int'({pck_en, mck_en}), 0);
    @(negedge clk); rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(act_cfg == '0, "R1 act_cfg after release", int'(act_cfg), 0);

    // Sweep of source, prescale (including reserved 7) and ratio
    for (int s = 0; s < SRC_N; s++) begin
      for (int p = 0; p < 8; p++) begin
        for (int r = 0; r < 4; r++) begin
          w = mk(s, p, r);
          wr(w);
          wait_applied(w, "R7 config applied");
          measure(per[s] * ((p == 7) ? 1 : (1 << p)), r + 1);
        end
      end
    end

    // R8: write coinciding with a boundary (boundary every cycle)
    w = mk(2, 0, 0);
    wr(w);
    wait_applied(w, "R8 setup");
    a = mk(2, 1, 1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = a;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(act_cfg == w, "R8 not applied at coinciding boundary", int'(act_cfg), int'(w));
    @(negedge clk);
    chk(act_cfg == a, "R8 applied at next boundary", int'(act_cfg), int'(a));
    measure(2, 2);

    // R7 and R8: mid-period writes on a long period, last one wins
    w = mk(0, 6, 3);
    wr(w);
    wait_applied(w, "R7 long setup");
    repeat (10) @(negedge clk);
    a = mk(1, 0, 0);
    b = mk(3, 2, 1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = a;
    @(negedge clk);
    cfg_wdata = b;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(act_cfg == w, "R7 no change mid-period", int'(act_cfg), int'(w));
    begin
      int n = 0;
      while (act_cfg == w && n < 4000) begin @(negedge clk); n++; end
      chk(mck_en, "R7 change with mck_en", int'(mck_en), 1);
      chk(n > 100, "R7 waited for period end", n, 101);
    end
    chk(act_cfg == b, "R8 last write wins", int'(act_cfg), int'(b));
    measure(2 * 4, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule